// File: doc/BRIEF.md
# Signed bit-field extract and insert unit

This block is a single-cycle ALU slice for 64-bit operands that works on a bit field. The field is described by a start position and a width. Each request carries a 2-bit operation select, a 64-bit source word, a 5-bit start position and a 5-bit width field. The width field holds the field width minus one, so a field is 1 to 32 bits wide.

There are two families of operation, and each has a high variant that adds 32 to the start position. Extraction pulls the field out of the source, moves it to bit 0 and fills every bit above it with copies of the field's top bit. Insertion takes the low bits of the source, places them at the start position and clears every other bit of the result; it does not merge into an old value.

The result and a valid flag are registered. They appear on the clock edge after the request is accepted. Register-file access and instruction decode sit outside the block.

Top module: `bfx_unit`

## Requirements
- R1: While reset is high, `res_valid` and `res_data` are zero on the following clock edge.
- R2: `req_op` encodes 0 = extract, 1 = extract with start `req_pos`+32, 2 = insert, 3 = insert with start `req_pos`+32. The field width is `req_lenm1`+1 bits in every mode.
- R3: For an extract whose field ends at or below bit 63, `res_data` bits 0..`req_lenm1` equal source bits start..start+`req_lenm1`. Every higher result bit equals source bit start+`req_lenm1`.
- R4: For an extract whose field would pass bit 63, the field is cut at bit 63. Result bits 0..63-start hold source bits start..63, and all higher result bits copy source bit 63.
- R5: For an insert, `res_data` bits start..start+`req_lenm1` equal source bits 0..`req_lenm1`, and every other result bit is zero.
- R6: For an insert whose field would pass bit 63, field bits that would land above bit 63 are discarded, and the placed part follows R5.
- R7: `res_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `res_data` carries that request's result in the same cycle.
- R8: In a cycle where `req_valid` is low, `res_data` keeps its value whatever the other request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation select (see R2) |
| req_src | input | 64 | Source operand |
| req_pos | input | 5 | Field start position before any +32 offset |
| req_lenm1 | input | 5 | Field width minus one |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | 64 | Registered result |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request. They also assume that the request inputs are 2-state whenever `req_valid` is high. The bench keeps to this by driving every input to a defined value before releasing reset, and it changes inputs only on falling edges. Inside that envelope, the bench sweeps every start and width for all four operations. For each case it forces the field's top source bit both set and clear, so sign fill and zero fill are each exercised at every boundary.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    parameter int DATA_W = 64;
    parameter int POS_W  = 5;
    parameter int LEN_W  = 5;

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int HI_OFS = DATA_W / 2;

    typedef enum logic [1:0] {
        OP_EXT    = 2'd0,
        OP_EXT_HI = 2'd1,
        OP_INS    = 2'd2,
        OP_INS_HI = 2'd3
    } bfx_op_e;

    typedef struct packed {
        logic [IDX_W-1:0] start;  // effective first bit of the field
        logic [IDX_W-1:0] top;    // last field bit kept inside the word
        logic             is_ins; // insert family
    } bfx_geom_t;

    function automatic logic [DATA_W-1:0] low_ones(input logic [LEN_W-1:0] lenm1);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i <= int'(lenm1));
        end
        return m;
    endfunction

endpackage

// File: rtl/bfx_geom.sv
module bfx_geom
    import bfx_pkg::*;
(
    input  logic [1:0]       op,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] lenm1,
    output bfx_geom_t        geom
);
    localparam int END_W = IDX_W + 1;

    bfx_op_e          op_e;
    logic [IDX_W-1:0] start_w;
    logic [END_W-1:0] end_w;

    always_comb begin
        op_e    = bfx_op_e'(op);
        start_w = IDX_W'(pos);
        if (op_e == OP_EXT_HI || op_e == OP_INS_HI) begin
            start_w = IDX_W'(pos) + IDX_W'(HI_OFS);
        end
        end_w = {1'b0, start_w} + END_W'(lenm1);
        geom.start  = start_w;
        geom.top    = (end_w > END_W'(DATA_W - 1)) ? IDX_W'(DATA_W - 1) : end_w[IDX_W-1:0];
        geom.is_ins = (op_e == OP_INS) || (op_e == OP_INS_HI);
    end

endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
    import bfx_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [IDX_W-1:0]  start,
    input  logic [IDX_W-1:0]  top,
    output logic [DATA_W-1:0] result
);
    logic [IDX_W-1:0]  up_sh;
    logic [IDX_W-1:0]  dn_sh;
    logic [DATA_W-1:0] lifted;

    always_comb begin
        // move the field top to the word top, then shift back arithmetically
        up_sh  = IDX_W'(DATA_W - 1) - top;
        dn_sh  = up_sh + start;
        lifted = src << up_sh;
        result = DATA_W'($signed(lifted) >>> dn_sh);
    end

endmodule

// File: rtl/bfx_insert.sv
module bfx_insert
    import bfx_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [IDX_W-1:0]  start,
    input  logic [LEN_W-1:0]  lenm1,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] field;

    always_comb begin
        field  = src & low_ones(lenm1);
        result = field << start;
    end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [63:0]       req_src,
    input  logic [4:0]        req_pos,
    input  logic [4:0]        req_lenm1,
    output logic              res_valid,
    output logic [63:0]       res_data
);
    bfx_geom_t         geom;
    logic [DATA_W-1:0] ext_res;
    logic [DATA_W-1:0] ins_res;
    logic [DATA_W-1:0] next_res;

    bfx_geom u_geom (
        .op    (req_op),
        .pos   (req_pos),
        .lenm1 (req_lenm1),
        .geom  (geom)
    );

    bfx_extract u_ext (
        .src    (req_src),
        .start  (geom.start),
        .top    (geom.top),
        .result (ext_res)
    );

    bfx_insert u_ins (
        .src    (req_src),
        .start  (geom.start),
        .lenm1  (req_lenm1),
        .result (ins_res)
    );

    assign next_res = geom.is_ins ? ins_res : ext_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_data <= next_res;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!res_valid && res_data == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) req_valid |=> res_valid); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !res_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !req_valid |=> $stable(res_data)); // R8
    AST_EXT_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_op[1]) |=>
        (($signed(res_data) >>> $past(req_lenm1)) == 64'sd0 ||
         ($signed(res_data) >>> $past(req_lenm1)) == -64'sd1)); // R3
    AST_INS_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1]) |=>
        ($countones(res_data) <= (int'($past(req_lenm1)) + 1))); // R5

endmodule

// File: tb/bfx_unit_bench.sv
module bfx_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [63:0] req_src = '0;
    logic [4:0]  req_pos = '0;
    logic [4:0]  req_lenm1 = '0;
    logic        res_valid;
    logic [63:0] res_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk; // 125 MHz

    bfx_unit u_bfx_unit (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_src   (req_src),
        .req_pos   (req_pos),
        .req_lenm1 (req_lenm1),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    function automatic logic [63:0] model(input int op, input int pos, input int n,
                                          input logic [63:0] src);
        logic [63:0] r;
        int eff;
        int last;
        eff  = pos + ((op % 2 == 1) ? 32 : 0);
        last = (eff + n > 63) ? 63 : eff + n;
        for (int i = 0; i < 64; i++) begin
            if (op < 2) begin
                r[i] = (eff + i <= last) ? src[eff + i] : src[last];
            end else begin
                r[i] = (i >= eff && i - eff <= n) ? src[i - eff] : 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] mix(input int k);
        logic [31:0] a;
        logic [31:0] b;
        a = 32'(k) * 32'h9E3779B9 + 32'h7F4A7C15;
        b = ~(32'(k) * 32'h85EBCA6B) ^ 32'hC2B2AE35;
        return {a, b};
    endfunction

    task automatic check(input string tag, input logic got_v, input logic [63:0] got,
                         input logic exp_v, input logic [63:0] exp);
        total++;
        if (got_v !== exp_v || got !== exp) begin
            bad++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, got_v, got, exp_v, exp);
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] last_res;
        repeat (3) @(negedge clk);
        check("R1", res_valid, res_data, 1'b0, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        last_res = 64'd0;
        for (int op = 0; op < 4; op++) begin
            for (int pos = 0; pos < 32; pos++) begin
                for (int n = 0; n < 32; n++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [63:0] src;
                        logic [63:0] exp;
                        int eff;
                        int last;
                        string tag;
                        eff  = pos + ((op % 2 == 1) ? 32 : 0);
                        last = (eff + n > 63) ? 63 : eff + n;
                        src  = mix(op * 4096 + pos * 64 + n * 2 + s);
                        // force the field's top bit both ways
                        if (op < 2) src[last] = s[0];
                        else        src[n]    = s[0];
                        exp = model(op, pos, n, src);
                        if (op < 2) tag = (eff + n > 63) ? "R2,R4,R7" : "R2,R3,R7";
                        else        tag = (eff + n > 63) ? "R2,R6,R7" : "R2,R5,R7";
                        req_valid = 1'b1;
                        req_op    = 2'(op);
                        req_src   = src;
                        req_pos   = 5'(pos);
                        req_lenm1 = 5'(n);
                        @(negedge clk);
                        check(tag, res_valid, res_data, 1'b1, exp);
                        last_res = exp;
                    end
                end
                // idle cycle with disturbed inputs: result must hold
                req_valid = 1'b0;
                req_op    = ~req_op;
                req_src   = ~req_src;
                req_pos   = ~req_pos;
                req_lenm1 = ~req_lenm1;
                @(negedge clk);
                check("R7,R8", res_valid, res_data, 1'b0, last_res);
            end
        end
        rst = 1'b1;
        @(negedge clk);
        check("R1", res_valid, res_data, 1'b0, 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule